// File: doc/BRIEF.md
# Program Memory Bank Remapper

This block sits between an instruction fetch unit and two physical flash banks. It takes a program-fetch address and decides which bank answers it, at what address inside that bank, and whether any bank answers it at all. The decision follows a two-bit mapping mode held in the block. One mode overlays a small bank on the bottom of the code space. One mode places the small bank high in the address map, beside the large bank at the bottom. The last two modes hide the small bank from fetches.

The mode register is loaded whenever the system is reset. The value it loads depends on two start-up configuration bits and on the cause of the reset: power-on/external, watchdog/brown-out, or software. After reset, software may flip the low bit of the mode through a small write port. The start-up bits themselves are stored outside the block and are only read here.

Each fetch strobe is translated in one clock cycle. The result is held on the outputs until the next accepted fetch.

Top module: `progBankMap`

## Requirements
- R1: With mode bit 1 set (modes 10 and 11), bank 1 (`bankSel`=1) is never selected. Fetches below 8000H go to bank 0 with `physAddr` equal to the fetch address and `unmapped`=0. Fetches at 8000H or above set `unmapped`=1, with `bankSel`=0 and `physAddr` equal to the fetch address.
- R2: In mode 01, fetches from E000H to FFFFH go to bank 1 with `physAddr` = address − E000H. Fetches below 8000H go to bank 0 with the address unchanged. Fetches from 8000H to DFFFH set `unmapped`=1, with `bankSel`=0 and the address unchanged.
- R3: In mode 00, fetches below 2000H go to bank 1 and all other fetches go to bank 0. In both cases `physAddr` equals the fetch address and `unmapped`=0.
- R4: A power-on/external reset loads the mode with the bitwise inverse of `scBits` = {SC1,SC0}.
- R5: A watchdog/brown-out reset loads mode bit 0 with NOT SC0. Mode bit 1 keeps its old value when SC1=1 and loads 1 when SC1=0.
- R6: A software reset loads the mode with {1, NOT SC0}, whatever the value of SC1.
- R7: A write (`wrEn`=1) replaces mode bit 0 with `wrData[0]`. `wrData[1]` is ignored. A write is also ignored in any cycle where a reset cause is active.
- R8: A fetch accepted at clock edge k shows its result, with `mapValid`=1, after edge k and uses the mode held before edge k. A write at the same edge therefore affects only later fetches. `mapValid` is 0 after any edge without an accepted fetch.
- R9: When several reset causes are active together, power-on/external wins over watchdog/brown-out, which wins over software. A fetch strobe in a cycle with any reset cause active is not accepted.
- R10: A power-on/external reset clears `bankSel`, `physAddr` and `unmapped` to 0. Otherwise these outputs keep their values at every edge without an accepted fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst | input | 1 | Power-on/external reset cause, active high, sampled at the clock edge |
| wdtRst | input | 1 | Watchdog/brown-out reset cause, active high |
| swRst | input | 1 | Software reset cause, active high |
| scBits | input | 2 | Start-up configuration bits {SC1,SC0} |
| wrEn | input | 1 | Mode write strobe |
| wrData | input | 2 | Mode write data; only bit 0 is used |
| fetchValid | input | 1 | Fetch strobe |
| fetchAddr | input | ADDR_W | Program-fetch address |
| mapValid | output | 1 | A fetch result is on the outputs this cycle |
| bankSel | output | 1 | Selected bank: 0 or 1 |
| physAddr | output | ADDR_W | Address inside the selected bank |
| unmapped | output | 1 | No bank answers the fetch |

## Verification
A mode write and a fetch can land on the same clock edge, and a reset cause can coincide with a write or a fetch. The bench provokes the write-plus-fetch collision with a directed case. In that case the fetch must be mapped with the old mode and the next fetch with the new one. It also drives both collisions at random throughout a long run. The reset-cause priority is probed by asserting two causes together and reading back the resulting mode through fetches at addresses that tell the modes apart.

// File: rtl/progBankPkg.sv
package progBankPkg;

  localparam logic [1:0] MODE_OVERLAY = 2'b00;
  localparam logic [1:0] MODE_SPLIT   = 2'b01;

  typedef struct packed {
    logic       capture;
    logic       wipe;
    logic [1:0] mode;
  } bankStrobeT;

endpackage

// File: rtl/progBankCtrl.sv
module progBankCtrl
  import progBankPkg::*;
(
  input  logic       clk,
  input  logic       porRst,
  input  logic       wdtRst,
  input  logic       swRst,
  input  logic [1:0] scBits,
  input  logic       wrEn,
  input  logic [1:0] wrData,
  input  logic       fetchValid,
  output bankStrobeT strobe
);

  logic [1:0] modeQ;
  logic [1:0] modeD;
  logic       anyRst;

  assign anyRst = porRst | wdtRst | swRst;

  // Reset-cause priority: power-on, then watchdog, then software, then write
  always_comb begin
    modeD = modeQ;
    if (porRst) begin
      modeD = ~scBits;
    end else if (wdtRst) begin
      modeD[1] = scBits[1] ? modeQ[1] : 1'b1;
      modeD[0] = ~scBits[0];
    end else if (swRst) begin
      modeD = {1'b1, ~scBits[0]};
    end else if (wrEn) begin
      modeD[0] = wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    modeQ <= modeD;
  end

  always_comb begin
    strobe.capture = fetchValid & ~anyRst;
    strobe.wipe    = porRst;
    strobe.mode    = modeQ;
  end

  // R4
  a_r4_por_load: assert property (@(posedge clk)
    porRst |=> modeQ == ~$past(scBits));

  // R5
  a_r5_wdt_keep: assert property (@(posedge clk) disable iff (porRst)
    (wdtRst && scBits[1]) |=> (modeQ[1] == $past(modeQ[1])) && (modeQ[0] == ~$past(scBits[0])));

  // R6 and R9
  a_r6_sw_load: assert property (@(posedge clk) disable iff (porRst)
    (swRst && !wdtRst) |=> modeQ == {1'b1, ~$past(scBits[0])});

  // R7
  a_r7_wr_bit0: assert property (@(posedge clk) disable iff (porRst)
    (wrEn && !wdtRst && !swRst) |=> (modeQ[0] == $past(wrData[0])) && $stable(modeQ[1]));

  // R7
  a_r7_bit1_ignored: assert property (@(posedge clk) disable iff (porRst)
    (wrEn && !anyRst && (wrData[1] != modeQ[1])) |=> modeQ[1] == $past(modeQ[1]));

endmodule

// File: rtl/progBankPath.sv
module progBankPath
  import progBankPkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SPLIT_BASE  = 'h8000,
  parameter int unsigned HIGH_BASE   = 'hE000,
  parameter int unsigned OVERLAY_TOP = 'h2000
) (
  input  logic              clk,
  input  bankStrobeT        strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              mapValid,
  output logic              bankSel,
  output logic [ADDR_W-1:0] physAddr,
  output logic              unmapped
);

  localparam logic [ADDR_W-1:0] splitLim = ADDR_W'(SPLIT_BASE);
  localparam logic [ADDR_W-1:0] highBase = ADDR_W'(HIGH_BASE);
  localparam logic [ADDR_W-1:0] ovlLim   = ADDR_W'(OVERLAY_TOP);

  logic              bankD;
  logic              unmD;
  logic [ADDR_W-1:0] physD;

  always_comb begin
    bankD = 1'b0;
    unmD  = 1'b0;
    physD = fetchAddr;
    case (strobe.mode)
      MODE_OVERLAY: begin
        if (fetchAddr < ovlLim) bankD = 1'b1;
      end
      MODE_SPLIT: begin
        if (fetchAddr >= highBase) begin
          bankD = 1'b1;
          physD = fetchAddr - highBase;
        end else if (fetchAddr >= splitLim) begin
          unmD = 1'b1;
        end
      end
      default: begin
        if (fetchAddr >= splitLim) unmD = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.wipe) begin
      mapValid <= 1'b0;
      bankSel  <= 1'b0;
      physAddr <= '0;
      unmapped <= 1'b0;
    end else begin
      mapValid <= strobe.capture;
      if (strobe.capture) begin
        bankSel  <= bankD;
        physAddr <= physD;
        unmapped <= unmD;
      end
    end
  end

  // R1
  a_r1_no_bank1: assert property (@(posedge clk) disable iff (strobe.wipe)
    (strobe.capture && strobe.mode[1]) |=> (mapValid && !bankSel));

  // R2
  a_r2_high_offset: assert property (@(posedge clk) disable iff (strobe.wipe)
    (strobe.capture && strobe.mode == MODE_SPLIT && fetchAddr >= highBase)
      |=> (bankSel && !unmapped && physAddr == $past(fetchAddr) - highBase));

  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (strobe.wipe)
    !strobe.capture |=> !mapValid);

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (strobe.wipe)
    !strobe.capture |=> ($stable(bankSel) && $stable(physAddr) && $stable(unmapped)));

endmodule

// File: rtl/progBankMap.sv
module progBankMap
  import progBankPkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SPLIT_BASE  = 'h8000,
  parameter int unsigned HIGH_BASE   = 'hE000,
  parameter int unsigned OVERLAY_TOP = 'h2000
) (
  input  logic              clk,
  input  logic              porRst,
  input  logic              wdtRst,
  input  logic              swRst,
  input  logic [1:0]        scBits,
  input  logic              wrEn,
  input  logic [1:0]        wrData,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              mapValid,
  output logic              bankSel,
  output logic [ADDR_W-1:0] physAddr,
  output logic              unmapped
);

  bankStrobeT strobe;

  progBankCtrl u_ctrl (
    .clk        (clk),
    .porRst     (porRst),
    .wdtRst     (wdtRst),
    .swRst      (swRst),
    .scBits     (scBits),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .fetchValid (fetchValid),
    .strobe     (strobe)
  );

  progBankPath #(
    .ADDR_W      (ADDR_W),
    .SPLIT_BASE  (SPLIT_BASE),
    .HIGH_BASE   (HIGH_BASE),
    .OVERLAY_TOP (OVERLAY_TOP)
  ) u_path (
    .clk       (clk),
    .strobe    (strobe),
    .fetchAddr (fetchAddr),
    .mapValid  (mapValid),
    .bankSel   (bankSel),
    .physAddr  (physAddr),
    .unmapped  (unmapped)
  );

endmodule

// File: tb/sim_progBankMap.sv
module sim_progBankMap;

  logic        clk = 1'b0;
  logic        porRst = 1'b1;
  logic        wdtRst = 1'b0;
  logic        swRst = 1'b0;
  logic [1:0]  scBits = 2'b11;
  logic        wrEn = 1'b0;
  logic [1:0]  wrData = 2'b00;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchAddr = 16'h0;
  logic        mapValid;
  logic        bankSel;
  logic [15:0] physAddr;
  logic        unmapped;

  int checks = 0;
  int errors = 0;

  logic [1:0]  mMode = 2'b00;
  logic        mValid = 1'b0;
  logic        mBank = 1'b0;
  logic [15:0] mPhys = 16'h0;
  logic        mUnm = 1'b0;

  always #10 clk = ~clk;

  progBankMap u0 (
    .clk(clk), .porRst(porRst), .wdtRst(wdtRst), .swRst(swRst), .scBits(scBits),
    .wrEn(wrEn), .wrData(wrData), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .mapValid(mapValid), .bankSel(bankSel), .physAddr(physAddr), .unmapped(unmapped)
  );

  function automatic logic [17:0] expMap(input logic [1:0] mode, input logic [15:0] a);
    logic b, u;
    logic [15:0] p;
    b = 1'b0; u = 1'b0; p = a;
    if (mode == 2'b00) begin
      b = (a < 16'h2000);
    end else if (mode == 2'b01) begin
      if (a >= 16'hE000) begin b = 1'b1; p = a - 16'hE000; end
      else if (a >= 16'h8000) u = 1'b1;
    end else begin
      u = (a >= 16'h8000);
    end
    return {b, u, p};
  endfunction

  function automatic logic [1:0] expNextMode(input logic [1:0] cur, input logic por,
      input logic wdt, input logic sw, input logic [1:0] sc, input logic we, input logic [1:0] wd);
    logic [1:0] n;
    n = cur;
    if (por) n = ~sc;
    else if (wdt) n = {sc[1] ? cur[1] : 1'b1, ~sc[0]};
    else if (sw) n = {1'b1, ~sc[0]};
    else if (we) n[0] = wd[0];
    return n;
  endfunction

  task automatic check1(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic por, input logic wdt, input logic sw,
      input logic [1:0] sc, input logic we, input logic [1:0] wd, input logic fv, input logic [15:0] fa);
    logic [17:0] m;
    porRst = por; wdtRst = wdt; swRst = sw; scBits = sc;
    wrEn = we; wrData = wd; fetchValid = fv; fetchAddr = fa;
    @(posedge clk);
    if (por) begin
      mValid = 1'b0; mBank = 1'b0; mPhys = 16'h0; mUnm = 1'b0;
    end else if (wdt || sw || !fv) begin
      mValid = 1'b0;
    end else begin
      m = expMap(mMode, fa);
      mValid = 1'b1; mBank = m[17]; mUnm = m[16]; mPhys = m[15:0];
    end
    mMode = expNextMode(mMode, por, wdt, sw, sc, we, wd);
    @(negedge clk);
    check1(tag, "mapValid", {15'h0, mapValid}, {15'h0, mValid});
    check1(tag, "bankSel", {15'h0, bankSel}, {15'h0, mBank});
    check1(tag, "unmapped", {15'h0, unmapped}, {15'h0, mUnm});
    check1(tag, "physAddr", physAddr, mPhys);
  endtask

  task automatic fetch(input string tag, input logic [15:0] a);
    step(tag, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'b00, 1'b1, a);
  endtask

  function automatic string modeTag(input logic [1:0] m);
    if (m == 2'b00) return "R3";
    if (m == 2'b01) return "R2";
    return "R1";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R4 and R10: power-on reset state, outputs cleared
    step("R10", 1, 0, 0, 2'b11, 0, 2'b00, 0, 16'h0);
    step("R4", 1, 0, 0, 2'b11, 0, 2'b00, 0, 16'h0);
    // R4: sc=11 -> mode 00 (overlay), R3 boundaries
    fetch("R4", 16'h1234);
    fetch("R3", 16'h1FFF);
    fetch("R3", 16'h2000);
    fetch("R3", 16'hFFFF);
    // R10: hold with no fetch
    step("R10", 0, 0, 0, 2'b00, 0, 2'b00, 0, 16'h5555);
    // R4: sc=10 -> mode 01
    step("R4", 1, 0, 0, 2'b10, 0, 2'b00, 0, 16'h0);
    fetch("R4", 16'hF000);
    fetch("R2", 16'h7FFF);
    fetch("R2", 16'h8000);
    fetch("R2", 16'hDFFF);
    fetch("R2", 16'hE000);
    fetch("R2", 16'hFFFF);
    // R4: sc=01 -> mode 10, sc=00 -> mode 11
    step("R4", 1, 0, 0, 2'b01, 0, 2'b00, 0, 16'h0);
    fetch("R4", 16'h9000);
    fetch("R1", 16'h7FFF);
    fetch("R1", 16'h0000);
    step("R4", 1, 0, 0, 2'b00, 0, 2'b00, 0, 16'h0);
    fetch("R4", 16'hE000);
    fetch("R1", 16'h8000);
    // R7: write 10 in mode 11 -> mode 10 (bit1 ignored), high fetch still unmapped
    step("R7", 0, 0, 0, 2'b00, 1, 2'b10, 0, 16'h0);
    fetch("R7", 16'h9000);
    // R7: from mode 00 write 01 -> 01, then write 10 -> 00
    step("R4", 1, 0, 0, 2'b11, 0, 2'b00, 0, 16'h0);
    step("R7", 0, 0, 0, 2'b00, 1, 2'b01, 0, 16'h0);
    fetch("R7", 16'hF000);
    step("R7", 0, 0, 0, 2'b00, 1, 2'b10, 0, 16'h0);
    fetch("R7", 16'h1000);
    // R8: write and fetch on the same edge: fetch uses old mode 00
    step("R8", 0, 0, 0, 2'b00, 1, 2'b01, 1, 16'h1000);
    fetch("R8", 16'h1000);
    fetch("R8", 16'hE004);
    // R9: fetch during reset not accepted; R7: write with reset ignored
    step("R9", 0, 0, 1, 2'b11, 1, 2'b01, 1, 16'h1000);
    fetch("R6", 16'h9000);
    // R5: mode 00, wdt with sc=11 keeps bit1=0 -> 00
    step("R4", 1, 0, 0, 2'b11, 0, 2'b00, 0, 16'h0);
    step("R5", 0, 1, 0, 2'b11, 0, 2'b00, 0, 16'h0);
    fetch("R5", 16'h0100);
    // R5: mode 1x, wdt with sc=10 -> 11; sc=01 -> 10
    step("R6", 0, 0, 1, 2'b00, 0, 2'b00, 0, 16'h0);
    step("R5", 0, 1, 0, 2'b10, 0, 2'b00, 0, 16'h0);
    fetch("R5", 16'hF000);
    step("R5", 0, 1, 0, 2'b01, 0, 2'b00, 0, 16'h0);
    fetch("R5", 16'hF000);
    // R6: software reset sc=10 from mode 00 -> 11
    step("R4", 1, 0, 0, 2'b11, 0, 2'b00, 0, 16'h0);
    step("R6", 0, 0, 1, 2'b10, 0, 2'b00, 0, 16'h0);
    fetch("R6", 16'hA000);
    // R9: por beats wdt; wdt beats sw
    step("R9", 1, 1, 1, 2'b10, 0, 2'b00, 0, 16'h0);
    fetch("R9", 16'hF000);
    step("R4", 1, 0, 0, 2'b11, 0, 2'b00, 0, 16'h0);
    step("R9", 0, 1, 1, 2'b10, 0, 2'b00, 0, 16'h0);
    fetch("R9", 16'hF000);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] r;
      logic [15:0] a;
      logic por, wdt, sw;
      r = 3'($urandom_range(0, 7));
      case (r)
        3'd0: a = 16'h1FFF + 16'($urandom_range(0, 2));
        3'd1: a = 16'h7FFF + 16'($urandom_range(0, 2));
        3'd2: a = 16'hDFFF + 16'($urandom_range(0, 2));
        default: a = 16'($urandom);
      endcase
      por = ($urandom_range(0, 99) < 2);
      wdt = ($urandom_range(0, 99) < 3);
      sw  = ($urandom_range(0, 99) < 3);
      step(modeTag(mMode), por, wdt, sw, 2'($urandom), ($urandom_range(0, 99) < 20),
           2'($urandom), ($urandom_range(0, 99) < 75), a);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule